// File: doc/BRIEF.md
# Segmented data-memory address unit

This unit sits between a processor's operand logic and its data RAM. It turns an 8-bit operand address, taken either from the instruction or from one of three pointer registers, into a 16-bit physical RAM address. Addresses with the top bit set land in a fixed, unextended upper window at 0x0080-0x00FF. Addresses with the top bit clear are placed in one of 256 segments of 128 bytes. A segment register picks the segment.

The top sixteen bytes of the fixed window (0xF0-0xFF) form a register file held inside the unit. The last four of these bytes are the two RAM pointers, the stack pointer and the segment register, so ordinary data writes can reload them. The two RAM pointers can be stepped up or down after an indirect access. The choice is made per access.

Window registers also support three single-cycle operations:
- decrement with a zero test;
- bit set and bit clear;
- bit test.

Address translation, read data and the zero flag are combinational. Register updates take effect at the next rising clock edge. The strobes are plain control pins with no back-pressure: the unit accepts one access every cycle.

Top module: `dmem_addr_unit`

## Requirements
- R1: When the effective address has bit 7 set, `phys_addr` is {8'h00, effective address} in the same cycle. The register window 0xF0-0xFF is therefore never segment-extended.
- R2: When the effective address has bit 7 clear, `phys_addr` is {S, 1'b0, address[6:0]} in the same cycle, where S is the window byte at 0xFF.
- R3: The pointer registers are window bytes: X at 0xFC, SP at 0xFD, B at 0xFE and S at 0xFF. A write to one of them changes the address used from the next cycle on.
- R4: After reset, B, X and S read 0x00 and SP reads 0x6F.
- R5: With `wr_en` high and the effective address in 0xF0-0xFF, the addressed byte takes `wdata` at the next edge. Whenever the effective address is in the window, `rdata` shows the addressed byte in the same cycle; outside the window it is 0x00.
- R6: `win_op`=1 (decrement-and-test) on a window byte with `wr_en` low loads the byte minus one, modulo 256, at the next edge. `zero_flag` is high in that same cycle exactly when the result is zero.
- R7: For `mode` 1 (via B) or 2 (via X) with any access active, `post_mod`=1 increments and `post_mod`=2 decrements that pointer modulo 256 at the next edge. An access is active when `rd_en`, `wr_en` or a nonzero `win_op` is present. `post_mod` 0 or 3 leaves it unchanged, and mode 3 (via SP) never modifies SP.
- R8: When a window write or a window modifying operation targets the same pointer that is being post-modified, the window result is stored and the post-modify is dropped.
- R9: With `wr_en` low, `win_op`=2 sets and `win_op`=3 clears bit `bit_sel` of the addressed window byte at the next edge. `win_op`=4 drives `zero_flag` high in the same cycle when that bit is 0. When `wr_en` is high, all window operations are ignored and `zero_flag` is low.
- R10: `mode` 0 uses `addr_in` as the effective address; modes 1, 2 and 3 use B, X and SP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 0 direct, 1 via B, 2 via X, 3 via SP |
| addr_in | input | 8 | Direct address |
| rd_en | input | 1 | Read access strobe |
| wr_en | input | 1 | Write access strobe |
| wdata | input | 8 | Write data for window bytes |
| win_op | input | 3 | 0 none, 1 decrement-test, 2 set bit, 3 clear bit, 4 test bit |
| bit_sel | input | 3 | Bit index for bit operations |
| post_mod | input | 2 | 0 none, 1 increment, 2 decrement, 3 none |
| phys_addr | output | 16 | Physical data-memory address |
| rdata | output | 8 | Addressed window byte, 0 outside the window |
| zero_flag | output | 1 | Decrement result zero or tested bit clear |

## Verification
`phys_addr`, `rdata` and `zero_flag` are due in the same cycle the inputs are applied. Register loads, bit changes, decrements and pointer steps appear one rising edge later. Each step of the bench drives its inputs just after a falling edge and compares the combinational outputs 1 ns later. It then updates its own model at the rising edge. The effect of every update is therefore observed through `rdata` or `phys_addr` in the following step.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [1:0] {
    AM_DIRECT = 2'd0,
    AM_VIA_B  = 2'd1,
    AM_VIA_X  = 2'd2,
    AM_VIA_SP = 2'd3
  } amode_e;

  typedef enum logic [2:0] {
    WOP_NONE = 3'd0,
    WOP_DECZ = 3'd1,
    WOP_SETB = 3'd2,
    WOP_CLRB = 3'd3,
    WOP_TSTB = 3'd4
  } winop_e;

  typedef enum logic [1:0] {
    PM_HOLD = 2'd0,
    PM_INC  = 2'd1,
    PM_DEC  = 2'd2,
    PM_RSVD = 2'd3
  } pmod_e;
endpackage

// File: rtl/dmem_addr_map.sv
module dmem_addr_map #(
  parameter int W        = 8,
  parameter int SW       = 8,
  parameter int WIN_BITS = 4
) (
  input  logic [W-1:0]    ea,
  input  logic [SW-1:0]   seg,
  output logic [SW+W-1:0] phys,
  output logic            win_hit
);
  always_comb begin
    if (ea[W-1]) phys = {{SW{1'b0}}, ea};
    else         phys = {seg, 1'b0, ea[W-2:0]};
  end

  assign win_hit = &ea[W-1:W-WIN_BITS];
endmodule

// File: rtl/dmem_win_regs.sv
module dmem_win_regs
  import dmem_pkg::*;
#(
  parameter int          W      = 8,
  parameter int          NREG   = 16,
  parameter logic [W-1:0] SP_RST = 8'h6F,
  localparam int         IB     = $clog2(NREG),
  localparam int         BB     = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IB-1:0] idx,
  input  logic          win_hit,
  input  logic          wr_en,
  input  logic [W-1:0]  wdata,
  input  winop_e        op,
  input  logic [BB-1:0] bit_idx,
  input  logic          mod_en,
  input  logic [IB-1:0] mod_sel,
  input  logic          mod_dec,
  output logic [W-1:0]  rdata,
  output logic          zero_flag,
  output logic [W-1:0]  ptr_x,
  output logic [W-1:0]  ptr_sp,
  output logic [W-1:0]  ptr_b,
  output logic [W-1:0]  seg
);
  localparam int IDX_X  = NREG - 4;
  localparam int IDX_SP = NREG - 3;
  localparam int IDX_B  = NREG - 2;
  localparam int IDX_S  = NREG - 1;

  logic [W-1:0] regs [NREG];
  logic [W-1:0] nxt  [NREG];
  logic [W-1:0] cur, dec_val, mask;
  logic         win_mod;

  assign cur     = regs[idx];
  assign dec_val = cur - W'(1);
  assign mask    = W'(1) << bit_idx;
  assign win_mod = win_hit && (wr_en || op == WOP_DECZ || op == WOP_SETB || op == WOP_CLRB);

  function automatic logic [W-1:0] rst_val(input int i);
    return (i == IDX_SP) ? SP_RST : '0;
  endfunction

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic sel_win, sel_mod;
    assign sel_win = win_mod && (idx == IB'(i));
    assign sel_mod = mod_en && (mod_sel == IB'(i));
    always_comb begin
      nxt[i] = regs[i];
      if (sel_win) begin
        if (wr_en)                nxt[i] = wdata;
        else if (op == WOP_DECZ)  nxt[i] = regs[i] - W'(1);
        else if (op == WOP_SETB)  nxt[i] = regs[i] | mask;
        else                      nxt[i] = regs[i] & ~mask;
      end else if (sel_mod) begin
        nxt[i] = mod_dec ? regs[i] - W'(1) : regs[i] + W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= rst_val(i);
    end else begin
      for (int i = 0; i < NREG; i++) regs[i] <= nxt[i];
    end
  end

  always_comb begin
    zero_flag = 1'b0;
    if (win_hit && !wr_en) begin
      if (op == WOP_DECZ)      zero_flag = (dec_val == '0);
      else if (op == WOP_TSTB) zero_flag = !cur[bit_idx];
    end
  end

  assign rdata  = win_hit ? cur : '0;
  assign ptr_x  = regs[IDX_X];
  assign ptr_sp = regs[IDX_SP];
  assign ptr_b  = regs[IDX_B];
  assign seg    = regs[IDX_S];

  logic [IB-1:0] chk_idx, chk_sel;
  logic [BB-1:0] chk_bit;
  logic [W-1:0]  chk_data, chk_old;
  logic          chk_dec;
  always_ff @(posedge clk) begin
    chk_idx  <= idx;
    chk_sel  <= mod_sel;
    chk_bit  <= bit_idx;
    chk_data <= wdata;
    chk_old  <= regs[mod_sel];
    chk_dec  <= mod_dec;
  end

  assert_wr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && wr_en) |=> (regs[chk_idx] == chk_data));

  assert_postmod_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !(win_mod && idx == mod_sel)) |=>
      (regs[chk_sel] == (chk_dec ? chk_old - W'(1) : chk_old + W'(1))));

  assert_decz_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && !wr_en && op == WOP_DECZ) |-> (zero_flag == (rdata == W'(1))));

  assert_setbit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && !wr_en && op == WOP_SETB) |=> regs[chk_idx][chk_bit]);
endmodule

// File: rtl/dmem_addr_unit.sv
module dmem_addr_unit
  import dmem_pkg::*;
#(
  parameter int          W        = 8,
  parameter int          SW       = 8,
  parameter int          WIN_BITS = 4,
  parameter logic [W-1:0] SP_RST  = 8'h6F,
  localparam int         NREG     = 1 << WIN_BITS,
  localparam int         BB       = $clog2(W),
  localparam int         PAW      = SW + W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     mode,
  input  logic [W-1:0]   addr_in,
  input  logic           rd_en,
  input  logic           wr_en,
  input  logic [W-1:0]   wdata,
  input  logic [2:0]     win_op,
  input  logic [BB-1:0]  bit_sel,
  input  logic [1:0]     post_mod,
  output logic [PAW-1:0] phys_addr,
  output logic [W-1:0]   rdata,
  output logic           zero_flag
);
  amode_e am;
  winop_e op;
  pmod_e  pm;
  logic [W-1:0]  ea, ptr_x, ptr_sp, ptr_b, seg;
  logic          win_hit, active, mod_en;
  logic [WIN_BITS-1:0] mod_sel;

  assign am = amode_e'(mode);
  assign op = winop_e'(win_op);
  assign pm = pmod_e'(post_mod);

  always_comb begin
    unique case (am)
      AM_DIRECT: ea = addr_in;
      AM_VIA_B:  ea = ptr_b;
      AM_VIA_X:  ea = ptr_x;
      default:   ea = ptr_sp;
    endcase
  end

  assign active  = rd_en || wr_en || (op != WOP_NONE);
  assign mod_en  = active && (am == AM_VIA_B || am == AM_VIA_X) &&
                   (pm == PM_INC || pm == PM_DEC);
  assign mod_sel = (am == AM_VIA_B) ? WIN_BITS'(NREG - 2) : WIN_BITS'(NREG - 4);

  dmem_addr_map #(.W(W), .SW(SW), .WIN_BITS(WIN_BITS)) u_map (
    .ea      (ea),
    .seg     (seg),
    .phys    (phys_addr),
    .win_hit (win_hit)
  );

  dmem_win_regs #(.W(W), .NREG(NREG), .SP_RST(SP_RST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (ea[WIN_BITS-1:0]),
    .win_hit   (win_hit),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .op        (op),
    .bit_idx   (bit_sel),
    .mod_en    (mod_en),
    .mod_sel   (mod_sel),
    .mod_dec   (pm == PM_DEC),
    .rdata     (rdata),
    .zero_flag (zero_flag),
    .ptr_x     (ptr_x),
    .ptr_sp    (ptr_sp),
    .ptr_b     (ptr_b),
    .seg       (seg)
  );

  assert_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (am == AM_DIRECT && addr_in[W-1]) |-> (phys_addr == PAW'(addr_in)));

  assert_segment_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (am == AM_DIRECT && !addr_in[W-1]) |->
      (phys_addr[PAW-1:W] == seg && phys_addr[W-1:0] == {1'b0, addr_in[W-2:0]}));
endmodule

// File: tb/sim_dmem_addr_unit.sv
module sim_dmem_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = '0;
  logic [7:0]  addr_in = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [2:0]  win_op = '0;
  logic [2:0]  bit_sel = '0;
  logic [1:0]  post_mod = '0;
  logic [15:0] phys_addr;
  logic [7:0]  rdata;
  logic        zero_flag;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] m [16];
  bit         ok [16];

  always #5 clk = ~clk;

  dmem_addr_unit u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr_in(addr_in), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .win_op(win_op), .bit_sel(bit_sel),
    .post_mod(post_mod), .phys_addr(phys_addr), .rdata(rdata), .zero_flag(zero_flag)
  );

  task automatic chk(input string t, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  function automatic logic [7:0] eff(input logic [1:0] md, input logic [7:0] ad);
    case (md)
      2'd0: return ad;
      2'd1: return m[14];
      2'd2: return m[12];
      default: return m[13];
    endcase
  endfunction

  function automatic logic [15:0] xlat(input logic [7:0] e);
    return e[7] ? {8'h00, e} : {m[15], 1'b0, e[6:0]};
  endfunction

  task automatic step(input string t, input logic [1:0] md, input logic [7:0] ad,
                      input bit r, input bit w, input logic [7:0] wd,
                      input logic [2:0] o, input logic [2:0] bi, input logic [1:0] pm);
    logic [7:0] e, nv [16];
    logic [3:0] ix;
    bit win, act;
    logic ez;
    mode = md; addr_in = ad; rd_en = r; wr_en = w; wdata = wd;
    win_op = o; bit_sel = bi; post_mod = pm;
    e = eff(md, ad); ix = e[3:0]; win = (e[7:4] == 4'hF);
    act = r || w || (o != 3'd0);
    #1;
    chk(t, "phys_addr", phys_addr, xlat(e));
    if (!win) chk(t, "rdata", {8'h00, rdata}, 16'h0000);
    else if (ok[ix]) chk(t, "rdata", {8'h00, rdata}, {8'h00, m[ix]});
    ez = 1'b0;
    if (win && !w && o == 3'd1) ez = (m[ix] == 8'h01);
    if (win && !w && o == 3'd4) ez = !m[ix][bi];
    if (!win || w || ok[ix]) chk(t, "zero_flag", {15'h0, zero_flag}, {15'h0, ez});
    for (int i = 0; i < 16; i++) nv[i] = m[i];
    if (act && (md == 2'd1 || md == 2'd2) && (pm == 2'd1 || pm == 2'd2)) begin
      int p;
      p = (md == 2'd1) ? 14 : 12;
      nv[p] = (pm == 2'd1) ? m[p] + 8'd1 : m[p] - 8'd1;
    end
    if (win) begin
      if (w) begin nv[ix] = wd; ok[ix] = 1'b1; end
      else if (o == 3'd1) nv[ix] = m[ix] - 8'd1;
      else if (o == 3'd2) nv[ix] = m[ix] | (8'd1 << bi);
      else if (o == 3'd3) nv[ix] = m[ix] & ~(8'd1 << bi);
    end
    @(posedge clk);
    for (int i = 0; i < 16; i++) m[i] = nv[i];
    @(negedge clk);
  endtask

  task automatic rd(input string t, input logic [7:0] ad);
    step(t, 2'd0, ad, 1'b1, 1'b0, 8'h00, 3'd0, 3'd0, 2'd0);
  endtask

  task automatic wr(input string t, input logic [7:0] ad, input logic [7:0] d);
    step(t, 2'd0, ad, 1'b0, 1'b1, d, 3'd0, 3'd0, 2'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    for (int i = 0; i < 16; i++) begin m[i] = 8'h00; ok[i] = 1'b0; end
    m[13] = 8'h6F;
    ok[12] = 1'b1; ok[13] = 1'b1; ok[14] = 1'b1; ok[15] = 1'b1;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset values
    rd("R4", 8'hFC); rd("R4", 8'hFD); rd("R4", 8'hFE); rd("R4", 8'hFF);
    rd("R2", 8'h05);
    // R5 load the general window bytes
    for (int i = 0; i < 12; i++) wr("R5", 8'hF0 + 8'(i), 8'(i * 17 + 3));
    for (int i = 0; i < 12; i++) rd("R5", 8'hF0 + 8'(i));
    rd("R5", 8'h40);
    // R3 segment register; R1 and R2 translation
    wr("R3", 8'hFF, 8'h01);
    rd("R2", 8'h05); rd("R2", 8'h7F); rd("R1", 8'h80); rd("R1", 8'hF3);
    // R10 indirect modes through pointers loaded at their mapped bytes
    wr("R3", 8'hFE, 8'h23);
    step("R10", 2'd1, 8'h00, 1'b1, 1'b0, 8'h00, 3'd0, 3'd0, 2'd0);
    wr("R3", 8'hFC, 8'h90);
    step("R10", 2'd2, 8'h00, 1'b1, 1'b0, 8'h00, 3'd0, 3'd0, 2'd0);
    step("R10", 2'd3, 8'h00, 1'b1, 1'b0, 8'h00, 3'd0, 3'd0, 2'd0);
    // R7 wrap of post modify, SP never modified, reserved code holds
    wr("R7", 8'hFE, 8'hFF);
    step("R7", 2'd1, 8'h00, 1'b1, 1'b0, 8'h00, 3'd0, 3'd0, 2'd1);
    rd("R7", 8'hFE);
    wr("R7", 8'hFC, 8'h00);
    step("R7", 2'd2, 8'h00, 1'b1, 1'b0, 8'h00, 3'd0, 3'd0, 2'd2);
    rd("R7", 8'hFC);
    step("R7", 2'd2, 8'h00, 1'b1, 1'b0, 8'h00, 3'd0, 3'd0, 2'd3);
    rd("R7", 8'hFC);
    step("R7", 2'd3, 8'h00, 1'b1, 1'b0, 8'h00, 3'd0, 3'd0, 2'd1);
    rd("R7", 8'hFD);
    // R8 pointer aimed at itself: window result wins over post modify
    wr("R8", 8'hFE, 8'hFE);
    step("R8", 2'd1, 8'h00, 1'b0, 1'b1, 8'h55, 3'd0, 3'd0, 2'd1);
    rd("R8", 8'hFE);
    wr("R8", 8'hFC, 8'hFC);
    step("R8", 2'd2, 8'h00, 1'b0, 1'b0, 8'h00, 3'd1, 3'd0, 2'd1);
    rd("R8", 8'hFC);
    // R6 decrement-and-test with zero result and wrap
    wr("R6", 8'hF1, 8'h01);
    step("R6", 2'd0, 8'hF1, 1'b0, 1'b0, 8'h00, 3'd1, 3'd0, 2'd0);
    rd("R6", 8'hF1);
    step("R6", 2'd0, 8'hF1, 1'b0, 1'b0, 8'h00, 3'd1, 3'd0, 2'd0);
    rd("R6", 8'hF1);
    // R9 bit set, test, clear; ignored under a write
    wr("R9", 8'hF2, 8'h00);
    step("R9", 2'd0, 8'hF2, 1'b0, 1'b0, 8'h00, 3'd2, 3'd5, 2'd0);
    rd("R9", 8'hF2);
    step("R9", 2'd0, 8'hF2, 1'b0, 1'b0, 8'h00, 3'd4, 3'd5, 2'd0);
    step("R9", 2'd0, 8'hF2, 1'b0, 1'b0, 8'h00, 3'd4, 3'd4, 2'd0);
    step("R9", 2'd0, 8'hF2, 1'b0, 1'b0, 8'h00, 3'd3, 3'd5, 2'd0);
    rd("R9", 8'hF2);
    step("R9", 2'd0, 8'hF2, 1'b0, 1'b1, 8'h07, 3'd4, 3'd3, 2'd0);
    rd("R9", 8'hF2);

    // constrained random mix
    for (int k = 0; k < 600; k++) begin
      logic [7:0] ad;
      bit w;
      logic [2:0] o;
      ad = ($urandom % 2) ? (8'hF0 | 8'($urandom % 16)) : 8'($urandom);
      w  = (($urandom % 4) == 0);
      o  = 3'($urandom % 5);
      step("R1 R2 R5 R6 R7 R9 random", 2'($urandom % 4), ad, 1'($urandom),
           w, 8'($urandom), o, 3'($urandom), 2'($urandom % 4));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule